// File: doc/BRIEF.md
# Frame-Luminance Backlight Dimmer

This block drives the pulse-width-modulated backlight pin of an LCD panel from the brightness of the video that the panel is showing. It watches a stream of luma samples, sums every valid sample between two frame-start pulses, and at each frame boundary turns that sum into a mean luminance. The mean is held for the whole of the following frame and also appears on an output for other logic.

A programmable linear map turns the held mean into a duty value between a lower and an upper limit. A mode input chooses between this automatic duty and a duty supplied directly by software. The PWM counter samples the chosen duty, and the mode, only when it wraps. A frame-rate change in brightness, or a mode switch, therefore never cuts a PWM pulse short.

Top module: `flb_backlight_pwm`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `pwm_o` is 0 and `frame_mean_o` is 0.
- R2: Only samples with `luma_vld_i` high add to the frame sum. A sample presented with `luma_vld_i` low changes nothing.
- R3: On a `frame_start_i` cycle other than the first one after reset, `frame_mean_o` takes the value floor(sum / `pix_count_i`), clamped to 255, in the following cycle. A `pix_count_i` of 0 gives 0. The value then holds until the next frame start.
- R4: A valid sample presented in the same cycle as `frame_start_i` belongs to the new frame, not to the frame that is closing.
- R5: The automatic duty is `duty_min_i` + floor((`duty_max_i` − `duty_min_i`) × mean / 255). When `duty_max_i` < `duty_min_i` it is `duty_min_i`.
- R6: The PWM counter counts 0 … `period_i`−1 and then wraps to 0. In each cycle where the counter holds value c, `pwm_o` is 1 exactly when c < active duty.
- R7: The active duty is reloaded only in the wrap cycle. The mode (`mode_auto_i` 1 = automatic, 0 = manual) and the duty inputs are sampled only then.
- R8: An active duty of 0 keeps `pwm_o` low for the whole period. An active duty ≥ `period_i` keeps it high.
- R9: In manual mode the duty loaded at the wrap is `man_duty_i`.
- R10: A `period_i` of 0 or 1 holds the counter at 0 and reloads on every cycle. `pwm_o` is then 1 exactly when the loaded duty is ≥ 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| luma_i | input | LUMA_W | Luma sample |
| luma_vld_i | input | 1 | Sample strobe |
| frame_start_i | input | 1 | One-cycle pulse at the start of each frame |
| mode_auto_i | input | 1 | 1 selects automatic duty, 0 selects manual duty |
| man_duty_i | input | PER_W | Manual duty |
| duty_min_i | input | PER_W | Lower limit of the automatic duty |
| duty_max_i | input | PER_W | Upper limit of the automatic duty |
| period_i | input | PER_W | PWM period in clocks |
| pix_count_i | input | CNT_W | Divisor used to form the mean |
| pwm_o | output | 1 | Backlight PWM output |
| frame_mean_o | output | LUMA_W | Mean luminance of the last complete frame |

## Verification
The bench goes after the frame boundary itself. If a design let the sample that arrives with the frame-start pulse leak into the old frame, or counted samples whose strobe was low, the mean would drift away from the model's value. The same follows if it updated the mean on the very first pulse after reset.

The bench also toggles the mode and the manual duty in the middle of a period. A design that reloaded the duty outside the wrap would cut a pulse short, and the per-cycle comparison would show it. Duties of 0, equal to the period and above it, periods of 0 and 1, reversed limits, a zero divisor and an undersized divisor that forces the clamp each pin down a place where an off-by-one comparison or a missing guard changes `pwm_o` or `frame_mean_o`.

// File: rtl/flb_pkg.sv
package flb_pkg;

   // Source of the duty loaded at each PWM wrap
   typedef enum logic {
      DUTY_SRC_MANUAL = 1'b0,
      DUTY_SRC_AUTO   = 1'b1
   } duty_src_e;

   // Last counter value for a given period; periods 0 and 1 both hold at 0
   function automatic logic [31:0] last_count(input logic [31:0] period);
      return (period == 32'd0) ? 32'd0 : period - 32'd1;
   endfunction

endpackage

// File: rtl/flb_frame_stats.sv
module flb_frame_stats #(
   parameter int LUMA_W    = 8,
   parameter int CNT_W     = 20,
   parameter bit USE_SHIFT = 1'b0,
   parameter int LOG2_PIX  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LUMA_W-1:0] luma_i,
   input  logic              luma_vld_i,
   input  logic              frame_start_i,
   input  logic [CNT_W-1:0]  pix_count_i,
   output logic [LUMA_W-1:0] mean_o
);
   localparam int SUM_W    = LUMA_W + CNT_W;
   localparam int MEAN_MAX = (1 << LUMA_W) - 1;

   logic [SUM_W-1:0]  acc_q;
   logic [SUM_W-1:0]  quot;
   logic [LUMA_W-1:0] mean_q;
   logic [LUMA_W-1:0] mean_c;
   logic              seen_q;

   // Divider variant chosen at elaboration
   generate
      if (USE_SHIFT) begin : g_shift
         always_comb quot = acc_q >> LOG2_PIX;
      end else begin : g_div
         always_comb begin
            if (pix_count_i == '0) quot = '0;
            else                   quot = acc_q / SUM_W'(pix_count_i);
         end
      end
   endgenerate

   always_comb begin
      if (quot > SUM_W'(MEAN_MAX)) mean_c = LUMA_W'(MEAN_MAX);
      else                         mean_c = quot[LUMA_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         mean_q <= '0;
         seen_q <= 1'b0;
      end else if (frame_start_i) begin
         if (seen_q) mean_q <= mean_c;
         seen_q <= 1'b1;
         acc_q  <= luma_vld_i ? SUM_W'(luma_i) : '0;
      end else if (luma_vld_i) begin
         acc_q  <= acc_q + SUM_W'(luma_i);
      end
   end

   assign mean_o = mean_q;

endmodule

// File: rtl/flb_duty_map.sv
module flb_duty_map #(
   parameter int LUMA_W = 8,
   parameter int PER_W  = 12
) (
   input  logic [LUMA_W-1:0] mean_i,
   input  logic [PER_W-1:0]  min_i,
   input  logic [PER_W-1:0]  max_i,
   output logic [PER_W-1:0]  duty_o
);
   localparam int PROD_W   = PER_W + LUMA_W;
   localparam int MEAN_MAX = (1 << LUMA_W) - 1;

   logic [PER_W-1:0]  span;
   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] scaled;

   always_comb begin
      span   = (max_i >= min_i) ? (max_i - min_i) : '0;
      prod   = PROD_W'(span) * PROD_W'(mean_i);
      scaled = prod / PROD_W'(MEAN_MAX);
      duty_o = min_i + scaled[PER_W-1:0];
   end

endmodule

// File: rtl/flb_pwm_core.sv
module flb_pwm_core
   import flb_pkg::*;
#(
   parameter int PER_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PER_W-1:0] period_i,
   input  logic [PER_W-1:0] duty_sel_i,
   output logic             pwm_o,
   output logic             wrap_o,
   output logic [PER_W-1:0] duty_act_o
);
   logic [PER_W-1:0] cnt_q, cnt_n;
   logic [PER_W-1:0] duty_q, duty_n;
   logic [PER_W-1:0] last_cnt;
   logic             pwm_q;
   logic             wrap;

   always_comb begin
      last_cnt = PER_W'(last_count(32'(period_i)));
      wrap     = (cnt_q >= last_cnt);
      cnt_n    = wrap ? '0 : cnt_q + 1'b1;
      duty_n   = wrap ? duty_sel_i : duty_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         duty_q <= '0;
         pwm_q  <= 1'b0;
      end else begin
         cnt_q  <= cnt_n;
         duty_q <= duty_n;
         pwm_q  <= (cnt_n < duty_n);
      end
   end

   assign pwm_o      = pwm_q;
   assign wrap_o     = wrap;
   assign duty_act_o = duty_q;

endmodule

// File: rtl/flb_backlight_pwm.sv
module flb_backlight_pwm
   import flb_pkg::*;
#(
   parameter int LUMA_W    = 8,
   parameter int CNT_W     = 20,
   parameter int PER_W     = 12,
   parameter bit USE_SHIFT = 1'b0,
   parameter int LOG2_PIX  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LUMA_W-1:0] luma_i,
   input  logic              luma_vld_i,
   input  logic              frame_start_i,
   input  logic              mode_auto_i,
   input  logic [PER_W-1:0]  man_duty_i,
   input  logic [PER_W-1:0]  duty_min_i,
   input  logic [PER_W-1:0]  duty_max_i,
   input  logic [PER_W-1:0]  period_i,
   input  logic [CNT_W-1:0]  pix_count_i,
   output logic              pwm_o,
   output logic [LUMA_W-1:0] frame_mean_o
);
   // Elaboration-time parameter checks
   generate
      if (LUMA_W < 2 || LUMA_W > 16) begin : g_bad_luma
         $error("flb_backlight_pwm: LUMA_W out of range");
      end
      if (PER_W < 2 || PER_W > 24) begin : g_bad_per
         $error("flb_backlight_pwm: PER_W out of range");
      end
      if (CNT_W < 1 || LUMA_W + CNT_W > 48) begin : g_bad_cnt
         $error("flb_backlight_pwm: CNT_W out of range");
      end
      if (USE_SHIFT && (LOG2_PIX < 0 || LOG2_PIX > CNT_W)) begin : g_bad_shift
         $error("flb_backlight_pwm: LOG2_PIX out of range");
      end
   endgenerate

   logic [LUMA_W-1:0] mean_w;
   logic [PER_W-1:0]  auto_duty_w;
   logic [PER_W-1:0]  sel_duty_w;
   logic [PER_W-1:0]  duty_act_w;
   logic              wrap_w;
   duty_src_e         src_w;

   flb_frame_stats #(
      .LUMA_W   (LUMA_W),
      .CNT_W    (CNT_W),
      .USE_SHIFT(USE_SHIFT),
      .LOG2_PIX (LOG2_PIX)
   ) u_stats (
      .clk          (clk),
      .rst_n        (rst_n),
      .luma_i       (luma_i),
      .luma_vld_i   (luma_vld_i),
      .frame_start_i(frame_start_i),
      .pix_count_i  (pix_count_i),
      .mean_o       (mean_w)
   );

   flb_duty_map #(
      .LUMA_W(LUMA_W),
      .PER_W (PER_W)
   ) u_map (
      .mean_i(mean_w),
      .min_i (duty_min_i),
      .max_i (duty_max_i),
      .duty_o(auto_duty_w)
   );

   always_comb begin
      src_w      = mode_auto_i ? DUTY_SRC_AUTO : DUTY_SRC_MANUAL;
      sel_duty_w = (src_w == DUTY_SRC_AUTO) ? auto_duty_w : man_duty_i;
   end

   flb_pwm_core #(
      .PER_W(PER_W)
   ) u_pwm (
      .clk       (clk),
      .rst_n     (rst_n),
      .period_i  (period_i),
      .duty_sel_i(sel_duty_w),
      .pwm_o     (pwm_o),
      .wrap_o    (wrap_w),
      .duty_act_o(duty_act_w)
   );

   assign frame_mean_o = mean_w;

endmodule

// File: rtl/flb_backlight_pwm_chk.sv
module flb_backlight_pwm_chk #(
   parameter int LUMA_W = 8,
   parameter int PER_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start_i,
   input logic [LUMA_W-1:0] frame_mean_o,
   input logic              pwm_o,
   input logic              wrap,
   input logic [PER_W-1:0]  sel_duty,
   input logic [PER_W-1:0]  duty_act,
   input logic [PER_W-1:0]  auto_duty,
   input logic [PER_W-1:0]  duty_min_i,
   input logic [PER_W-1:0]  duty_max_i,
   input logic [PER_W-1:0]  period_i
);
   AST_MEAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_start_i) |-> $stable(frame_mean_o)); // R3

   AST_DUTY_ONLY_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(duty_act)); // R7

   AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && sel_duty == '0) |=> !pwm_o); // R8

   AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && period_i != '0 && sel_duty >= period_i) |=> pwm_o); // R8

   AST_AUTO_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_max_i >= duty_min_i) |-> (auto_duty >= duty_min_i && auto_duty <= duty_max_i)); // R5

endmodule

bind flb_backlight_pwm flb_backlight_pwm_chk #(
   .LUMA_W(LUMA_W),
   .PER_W (PER_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frame_start_i(frame_start_i),
   .frame_mean_o (frame_mean_o),
   .pwm_o        (pwm_o),
   .wrap         (wrap_w),
   .sel_duty     (sel_duty_w),
   .duty_act     (duty_act_w),
   .auto_duty    (auto_duty_w),
   .duty_min_i   (duty_min_i),
   .duty_max_i   (duty_max_i),
   .period_i     (period_i)
);

// File: tb/sim_flb_backlight_pwm.sv
`timescale 1ns/1ps
module sim_flb_backlight_pwm;
   localparam int CLK_PERIOD = 10;
   localparam int LUMA_W = 8;
   localparam int CNT_W  = 20;
   localparam int PER_W  = 12;
   localparam int WD_CYCLES = 100000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [LUMA_W-1:0] luma = '0;
   logic              vld = 1'b0;
   logic              fs = 1'b0;
   logic              mode_auto = 1'b0;
   logic [PER_W-1:0]  man_duty = '0;
   logic [PER_W-1:0]  dmin = '0;
   logic [PER_W-1:0]  dmax = '0;
   logic [PER_W-1:0]  period = 12'd16;
   logic [CNT_W-1:0]  pix_cnt = '0;
   logic              pwm;
   logic [LUMA_W-1:0] mean;

   int vectors = 0;
   int fails = 0;
   bit done = 1'b0;
   string cur_req = "R1 reset state";

   always #(CLK_PERIOD/2) clk = ~clk;

   flb_backlight_pwm #(.LUMA_W(LUMA_W), .CNT_W(CNT_W), .PER_W(PER_W)) u0 (
      .clk(clk), .rst_n(rst_n), .luma_i(luma), .luma_vld_i(vld),
      .frame_start_i(fs), .mode_auto_i(mode_auto), .man_duty_i(man_duty),
      .duty_min_i(dmin), .duty_max_i(dmax), .period_i(period),
      .pix_count_i(pix_cnt), .pwm_o(pwm), .frame_mean_o(mean));

   // Behavioural reference model
   longint m_acc = 0;
   int     m_mean = 0, m_cnt = 0, m_duty = 0, m_last = 0, m_sel = 0;
   bit     m_seen = 0, m_pwm = 0, m_wrap = 0;

   function automatic int ref_mean(longint acc, int pc);
      longint q;
      if (pc == 0) return 0;
      q = acc / pc;
      return (q > 255) ? 255 : int'(q);
   endfunction

   function automatic int ref_auto(int mn, int mx, int mv);
      if (mx < mn) return mn;
      return mn + ((mx - mn) * mv) / 255;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_acc = 0; m_mean = 0; m_cnt = 0; m_duty = 0; m_seen = 0; m_pwm = 0;
      end else begin
         m_last = (period == 0) ? 0 : int'(period) - 1;
         m_wrap = (m_cnt >= m_last);
         m_sel  = mode_auto ? ref_auto(int'(dmin), int'(dmax), m_mean) : int'(man_duty);
         if (m_wrap) begin m_cnt = 0; m_duty = m_sel; end
         else m_cnt = m_cnt + 1;
         m_pwm = (m_cnt < m_duty);
         if (fs) begin
            if (m_seen) m_mean = ref_mean(m_acc, int'(pix_cnt));
            m_seen = 1;
            m_acc = vld ? longint'(luma) : 0;
         end else if (vld) begin
            m_acc = m_acc + longint'(luma);
         end
      end
   end

   task automatic compare();
      vectors++;
      if (pwm !== m_pwm) begin
         fails++;
         $display("FAIL %s: pwm_o=%0b expected %0b at %0t", cur_req, pwm, m_pwm, $time);
      end
      if (mean !== LUMA_W'(m_mean)) begin
         fails++;
         $display("FAIL %s: frame_mean_o=%0d expected %0d at %0t", cur_req, mean, m_mean, $time);
      end
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input bit f, input bit v, input int y);
      @(negedge clk);
      compare();
      fs = f; vld = v; luma = LUMA_W'(y);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 0);
   endtask

   // One frame of n cycles; every gap-th slot carries junk with strobe low
   task automatic frame(input int n, input int y0, input int stp, input int gap, input int pc_force);
      int cnt;
      cnt = 1;
      cyc(1'b1, 1'b1, y0);
      for (int i = 1; i < n; i++) begin
         if (gap != 0 && (i % gap) == 0) cyc(1'b0, 1'b0, 255);
         else begin cyc(1'b0, 1'b1, (y0 + i * stp) % 256); cnt++; end
      end
      @(negedge clk);
      compare();
      fs = 1'b0; vld = 1'b0; luma = '0;
      pix_cnt = (pc_force >= 0) ? CNT_W'(pc_force) : CNT_W'(cnt);
   endtask

   initial begin
      // R1: reset state
      repeat (4) begin @(negedge clk); compare(); chk(pwm == 1'b0 && mean == '0, "R1 reset", int'(pwm), 0); end
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk); compare(); chk(pwm == 1'b0 && mean == '0, "R1 first cycle", int'(mean), 0);

      cur_req = "R9 manual duty"; man_duty = 12'd5;
      idle(40);
      cur_req = "R6 counter compare"; man_duty = 12'd11;
      idle(34);

      cur_req = "R3 first frame start does not update mean";
      frame(40, 200, 0, 0, -1);
      chk(mean == '0, "R3 no update on first start", int'(mean), 0);
      cur_req = "R3 mean of constant frame";
      frame(40, 100, 0, 0, -1);
      @(negedge clk); compare();
      chk(mean == 8'd200, "R3 mean=200", int'(mean), 200);

      cur_req = "R5 automatic duty map"; mode_auto = 1'b1; dmin = 12'd2; dmax = 12'd14;
      frame(50, 10, 3, 0, -1);
      cur_req = "R2 strobe-low samples ignored";
      frame(60, 20, 5, 3, -1);
      frame(45, 40, 1, 4, -1);
      @(negedge clk); compare();
      cur_req = "R4 start-cycle sample joins new frame";
      frame(33, 250, 0, 0, -1);
      frame(33, 0, 0, 0, -1);
      frame(33, 0, 0, 0, -1);
      chk(mean == '0, "R4 mean of all-zero frame", int'(mean), 0);

      cur_req = "R7 mode change mid-period"; man_duty = 12'd3;
      idle(5); mode_auto = 1'b0; idle(7); mode_auto = 1'b1; idle(9);
      man_duty = 12'd9; mode_auto = 1'b0; idle(3); man_duty = 12'd1; idle(40);

      cur_req = "R8 duty 0 constant low"; man_duty = 12'd0; idle(40);
      cur_req = "R8 duty equal period constant high"; man_duty = 12'd16; idle(40);
      cur_req = "R8 duty above period constant high"; man_duty = 12'd30; idle(20);

      cur_req = "R10 period 1"; period = 12'd1; man_duty = 12'd1; idle(10);
      man_duty = 12'd0; idle(10);
      cur_req = "R10 period 0"; period = 12'd0; man_duty = 12'd2; idle(10);
      period = 12'd7; idle(20);

      cur_req = "R5 reversed limits"; mode_auto = 1'b1; dmin = 12'd6; dmax = 12'd3;
      frame(30, 90, 2, 0, -1); idle(20);
      cur_req = "R3 zero divisor gives zero"; dmin = 12'd0; dmax = 12'd7;
      frame(30, 60, 1, 0, 0);
      frame(30, 60, 1, 0, 4);
      cur_req = "R3 clamp to 255";
      frame(30, 60, 1, 0, -1); idle(2);
      chk(mean == 8'd255, "R3 clamp", int'(mean), 255);
      idle(20);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule